// File: doc/BRIEF.md
# Packet Receive Port with Threshold Backpressure

This block is the receive side of a 32-bit framed packet interface on a physical-layer device. A link-layer sender drives one data word per clock together with start, end, error, odd-parity and a 2-bit trailing-byte code. The word and its strobes are taken in only on cycles where the active-low enable is low. Each accepted word is tagged with a 4-bit byte-valid mask, start and end flags, and an error flag. The tagged word is then written into an internal queue, which a downstream consumer drains through a valid/ready read port.

Flow control goes back to the sender through a single registered room flag. The flag drops when the queue fill reaches a programmable stop level. It rises again only once the free space is strictly larger than a separate programmable resume level. A sender that honours the flag therefore never loses a word. A word that arrives while the queue is already full is discarded and does not disturb the stored contents. Framing mistakes by the sender are recorded in two places: the affected word carries its error tag, and a status bit is set that stays set until reset.

Top module: `pkt_rx_port`

## Requirements
- R1: While `rx_en_n` is high, all other inputs are ignored: nothing is written to the queue and the framing state and status bit keep their values.
- R2: Every accepted word is delivered on the read port in arrival order, with its 32 data bits, its start tag and its end tag unchanged.
- R3: On a word with end-of-packet set, `rd_bmask` (bit 3 = bits 31..24, bit 0 = bits 7..0) is decoded from `rx_mode`: 00 gives 1111, 01 gives 1110, 10 gives 1100 and 11 gives 1000.
- R4: On a word without end-of-packet, `rd_bmask` is 1111 whatever the value of `rx_mode`.
- R5: Parity is odd over the 32 data bits plus `rx_par`. A word whose parity does not match is stored with its error tag set.
- R6: A word accepted with `rx_err` high is stored with its error tag set.
- R7: A start-of-packet accepted while a packet is open is a framing violation. That word gets its error tag set and `framing_err` goes high and stays high until reset.
- R8: A word accepted with no start-of-packet while no packet is open is a framing violation, handled the same way as in R7. A word with end-of-packet set closes the open packet.
- R9: The registered `rx_room` goes low in the cycle after the queue fill reaches `stop_lvl`.
- R10: Once `rx_room` is low, it returns high only when the queue's free entries are strictly more than `resume_lvl`.
- R11: Reset leaves the queue empty, `rx_room` high and `framing_err` low. The head entry is removed only on a cycle with both `rd_valid` and `rd_ready` high, and it holds steady while it waits.
- R12: A word accepted while the queue holds DEPTH entries is dropped. The stored entries are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en_n | input | 1 | Active-low word enable from the sender |
| rx_data | input | 32 | Packet data, first byte in bits 31..24 |
| rx_sop | input | 1 | First word of a packet |
| rx_eop | input | 1 | Last word of a packet |
| rx_err | input | 1 | Sender-reported error on this word |
| rx_par | input | 1 | Odd parity bit for `rx_data` |
| rx_mode | input | 2 | Number of invalid trailing bytes on the last word |
| stop_lvl | input | CNT_W (5) | Fill level at which `rx_room` drops |
| resume_lvl | input | CNT_W (5) | `rx_room` returns once free entries exceed this level |
| rx_room | output | 1 | High while the sender may send |
| framing_err | output | 1 | Framing violation seen since reset |
| rd_ready | input | 1 | Consumer accepts the head entry |
| rd_valid | output | 1 | Head entry present |
| rd_data | output | 32 | Head entry data |
| rd_bmask | output | 4 | Head entry byte-valid mask |
| rd_sop | output | 1 | Head entry start tag |
| rd_eop | output | 1 | Head entry end tag |
| rd_err | output | 1 | Head entry error tag |

## Verification
The random phase sends packets of random length with random enable gaps, and a reader that stalls at random. While a word is not the last of its packet, its mode input is random, so any mask that follows `rx_mode` on a middle word is caught. While the enable is high, all other inputs carry random values, which shows whether the port really ignores them. Directed cases then send:
- single-word packets with each of the four mode codes, which separates the four mask decodes;
- a parity flip, and separately an error strobe, which shows each error source on its own;
- an orphan data word and a repeated start, which show each framing violation;
- a stalled reader with a low stop level and a higher resume level, which shows the hysteresis gap;
- forced writes into a full queue, which show the drop.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;
    localparam int BUS_BYTES = 4;
    localparam int BUS_W     = 8 * BUS_BYTES;
    localparam int MODE_W    = $clog2(BUS_BYTES);

    typedef struct packed {
        logic [BUS_W-1:0]     data;
        logic [BUS_BYTES-1:0] bmask;
        logic                 sop;
        logic                 eop;
        logic                 err;
    } rx_entry_t;
endpackage

// File: rtl/pkt_rx_framer.sv
module pkt_rx_framer
    import pkt_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_n,
    input  logic [BUS_W-1:0]  data,
    input  logic              sop,
    input  logic              eop,
    input  logic              err,
    input  logic              par,
    input  logic [MODE_W-1:0] mode,
    output logic              wr_req,
    output rx_entry_t         wr_entry,
    output logic              framing_err
);
    typedef struct packed {
        logic open;
        logic sticky;
    } frm_state_t;

    frm_state_t st_q, st_d;
    logic [BUS_BYTES-1:0] lane_ok;
    logic                 fire;
    logic                 par_bad;
    logic                 viol;

    // Lane i (i = 3 is the first byte) stays valid while i >= invalid count.
    for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
        assign lane_ok[i] = !eop || ((MODE_W+1)'(i) >= {1'b0, mode});
    end

    always_comb begin
        st_d    = st_q;
        fire    = !en_n;
        par_bad = !((^data) ^ par);
        // A start while open, or no start while closed, breaks framing.
        viol    = fire && (sop == st_q.open);
        if (fire) begin
            st_d.open   = !eop;
            st_d.sticky = st_q.sticky | viol;
        end
        wr_req         = fire;
        wr_entry.data  = data;
        wr_entry.bmask = lane_ok;
        wr_entry.sop   = sop;
        wr_entry.eop   = eop;
        wr_entry.err   = err | par_bad | viol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign framing_err = st_q.sticky;

    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |=> ($stable(st_q.open) && $stable(st_q.sticky)));
    p_mid_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !eop) |-> (wr_entry.bmask == '1));
    p_last_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && eop && mode == '1) |-> $onehot0(wr_entry.bmask) && wr_entry.bmask[BUS_BYTES-1]);
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        framing_err |=> framing_err);
endmodule

// File: rtl/pkt_rx_fifo.sv
module pkt_rx_fifo
    import pkt_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  rx_entry_t     wr_entry,
    input  logic          rd_ready,
    output logic          rd_valid,
    output rx_entry_t     rd_entry,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
    } fifo_state_t;

    fifo_state_t st_q, st_d;
    rx_entry_t   mem [DEPTH];
    logic        push;
    logic        pop;
    logic        full;

    always_comb begin
        st_d = st_q;
        full = (st_q.cnt == CW'(DEPTH));
        push = wr_req && !full;
        pop  = rd_ready && (st_q.cnt != '0);
        if (push) st_d.wptr = st_q.wptr + AW'(1);
        if (pop)  st_d.rptr = st_q.rptr + AW'(1);
        st_d.cnt = st_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[st_q.wptr] <= wr_entry;
    end

    assign rd_valid = (st_q.cnt != '0);
    assign rd_entry = mem[st_q.rptr];
    assign count    = st_q.cnt;

    p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && full && !rd_ready) |=> (count == CW'(DEPTH)));
    p_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_entry)));
endmodule

// File: rtl/pkt_rx_flow.sv
module pkt_rx_flow #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count_d,
    input  logic [CW-1:0] count_q,
    input  logic [CW-1:0] stop_lvl,
    input  logic [CW-1:0] resume_lvl,
    output logic          room
);
    logic room_q, room_d;
    logic [CW-1:0] free_d;

    always_comb begin
        free_d = CW'(DEPTH) - count_d;
        if (room_q) room_d = (count_d < stop_lvl);
        else        room_d = (free_d > resume_lvl);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) room_q <= 1'b1;
        else        room_q <= room_d;
    end

    assign room = room_q;

    p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        room_q |-> (count_q < stop_lvl));
    p_resume_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(room_q) |-> ((CW'(DEPTH) - count_q) > resume_lvl));
endmodule

// File: rtl/pkt_rx_port.sv
module pkt_rx_port
    import pkt_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_en_n,
    input  logic [BUS_W-1:0]     rx_data,
    input  logic                 rx_sop,
    input  logic                 rx_eop,
    input  logic                 rx_err,
    input  logic                 rx_par,
    input  logic [MODE_W-1:0]    rx_mode,
    input  logic [CNT_W-1:0]     stop_lvl,
    input  logic [CNT_W-1:0]     resume_lvl,
    output logic                 rx_room,
    output logic                 framing_err,
    input  logic                 rd_ready,
    output logic                 rd_valid,
    output logic [BUS_W-1:0]     rd_data,
    output logic [BUS_BYTES-1:0] rd_bmask,
    output logic                 rd_sop,
    output logic                 rd_eop,
    output logic                 rd_err
);
    localparam int AW = $clog2(DEPTH);

    logic             wr_req;
    rx_entry_t        wr_entry;
    rx_entry_t        rd_entry;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_d;
    logic             push_ok;
    logic             pop_ok;

    pkt_rx_framer u_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_n        (rx_en_n),
        .data        (rx_data),
        .sop         (rx_sop),
        .eop         (rx_eop),
        .err         (rx_err),
        .par         (rx_par),
        .mode        (rx_mode),
        .wr_req      (wr_req),
        .wr_entry    (wr_entry),
        .framing_err (framing_err)
    );

    pkt_rx_fifo #(.DEPTH(DEPTH), .AW(AW), .CW(CNT_W)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (wr_req),
        .wr_entry (wr_entry),
        .rd_ready (rd_ready),
        .rd_valid (rd_valid),
        .rd_entry (rd_entry),
        .count    (count_q)
    );

    // Fill after this edge, seen from the port side of the queue.
    always_comb begin
        push_ok = wr_req && (count_q != CNT_W'(DEPTH));
        pop_ok  = rd_ready && rd_valid;
        count_d = count_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end

    pkt_rx_flow #(.DEPTH(DEPTH), .CW(CNT_W)) u_flow (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_d    (count_d),
        .count_q    (count_q),
        .stop_lvl   (stop_lvl),
        .resume_lvl (resume_lvl),
        .room       (rx_room)
    );

    assign rd_data  = rd_entry.data;
    assign rd_bmask = rd_entry.bmask;
    assign rd_sop   = rd_entry.sop;
    assign rd_eop   = rd_entry.eop;
    assign rd_err   = rd_entry.err;
endmodule

// File: tb/tb_pkt_rx_port.sv
module tb_pkt_rx_port;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en_n = 1'b1;
    logic [31:0] rx_data = '0;
    logic rx_sop = 1'b0, rx_eop = 1'b0, rx_err = 1'b0, rx_par = 1'b0;
    logic [1:0] rx_mode = '0;
    logic [CW-1:0] stop_lvl = CW'(12), resume_lvl = CW'(6);
    logic rx_room, framing_err, rd_ready = 1'b0, rd_valid;
    logic [31:0] rd_data;
    logic [3:0] rd_bmask;
    logic rd_sop, rd_eop, rd_err;

    pkt_rx_port #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .rx_en_n(rx_en_n), .rx_data(rx_data),
        .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_err(rx_err), .rx_par(rx_par),
        .rx_mode(rx_mode), .stop_lvl(stop_lvl), .resume_lvl(resume_lvl),
        .rx_room(rx_room), .framing_err(framing_err), .rd_ready(rd_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_bmask(rd_bmask),
        .rd_sop(rd_sop), .rd_eop(rd_eop), .rd_err(rd_err)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [31:0] d;
        logic [3:0]  m;
        logic        s, e, x;
        string       why;
    } exp_t;

    exp_t mq[$];
    int   n_checks = 0;
    int   n_errors = 0;
    int   pops = 0;
    bit   m_open = 0, m_sticky = 0, m_room = 1;
    bit   done = 0;

    function automatic logic [3:0] exp_mask(bit eop, logic [1:0] md);
        if (!eop) return 4'hF;
        return 4'(4'hF << md);
    endfunction

    function automatic logic odd_par(logic [31:0] d);
        return ~(^d);
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    task automatic check_outputs();
        chk(rd_valid == (mq.size() != 0), "R11", 64'(rd_valid), 64'(mq.size() != 0));
        if (rd_valid && mq.size() != 0) begin
            chk(rd_data == mq[0].d, "R2", 64'(rd_data), 64'(mq[0].d));
            chk(rd_sop == mq[0].s && rd_eop == mq[0].e, "R2",
                64'({rd_sop, rd_eop}), 64'({mq[0].s, mq[0].e}));
            chk(rd_bmask == mq[0].m, mq[0].e ? "R3" : "R4", 64'(rd_bmask), 64'(mq[0].m));
            chk(rd_err == mq[0].x, mq[0].why, 64'(rd_err), 64'(mq[0].x));
        end
        chk(rx_room == m_room, "R9", 64'(rx_room), 64'(m_room));
        chk(framing_err == m_sticky, "R7", 64'(framing_err), 64'(m_sticky));
    endtask

    // Called just after a falling edge; returns just after the next one.
    task automatic step(bit en_n, logic [31:0] d, bit s, bit e, bit er,
                        bit bad, logic [1:0] md, bit rdy);
        bit   pop, wr, viol;
        exp_t ent;
        check_outputs();
        rx_en_n  = en_n;
        rx_data  = d;
        rx_sop   = s;
        rx_eop   = e;
        rx_err   = er;
        rx_par   = odd_par(d) ^ bad;
        rx_mode  = md;
        rd_ready = rdy;
        pop = rdy && (mq.size() != 0);
        if (pop) pops++;
        wr  = !en_n && (mq.size() < DEPTH);
        if (!en_n) begin
            viol     = (s == m_open);
            m_open   = !e;
            m_sticky = m_sticky | viol;
            ent.d = d; ent.m = exp_mask(e, md); ent.s = s; ent.e = e;
            ent.x = er | bad | viol;
            ent.why = viol ? (s ? "R7" : "R8") : (bad ? "R5" : (er ? "R6" : "R5"));
            if (pop) void'(mq.pop_front());
            if (wr) mq.push_back(ent);
        end else if (pop) begin
            void'(mq.pop_front());
        end
        if (m_room) m_room = (mq.size() < int'(stop_lvl));
        else        m_room = ((DEPTH - mq.size()) > int'(resume_lvl));
        @(negedge clk);
    endtask

    task automatic idle(int n, bit rdy);
        for (int i = 0; i < n; i++)
            step(1'b1, $urandom, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 2'($urandom), rdy);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : main
        bit in_pkt;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(rd_valid == 1'b0, "R11", 64'(rd_valid), 64'd0);
        chk(rx_room == 1'b1, "R11", 64'(rx_room), 64'd1);
        chk(framing_err == 1'b0, "R11", 64'(framing_err), 64'd0);

        // R1: enable high with random strobes
        idle(10, 1'b0);
        chk(rd_valid == 1'b0, "R1", 64'(rd_valid), 64'd0);
        chk(framing_err == 1'b0, "R1", 64'(framing_err), 64'd0);

        // R3: each mode code on a single-word packet
        for (int k = 0; k < 4; k++)
            step(1'b0, $urandom, 1, 1, 0, 0, 2'(k), 1'b0);
        idle(8, 1'b1);
        // R4: middle words with mode 11
        step(1'b0, $urandom, 1, 0, 0, 0, 2'b11, 1'b1);
        step(1'b0, $urandom, 0, 0, 0, 0, 2'b11, 1'b1);
        step(1'b0, $urandom, 0, 1, 0, 0, 2'b10, 1'b1);
        // R5 parity flip, R6 error strobe
        step(1'b0, $urandom, 1, 0, 0, 1, 2'b00, 1'b1);
        step(1'b0, $urandom, 0, 1, 1, 0, 2'b01, 1'b1);
        idle(6, 1'b1);
        chk(framing_err == 1'b0, "R5", 64'(framing_err), 64'd0);

        // R8: orphan word
        step(1'b0, 32'hA5A5_0001, 0, 1, 0, 0, 2'b00, 1'b1);
        idle(2, 1'b1);
        chk(framing_err == 1'b1, "R8", 64'(framing_err), 64'd1);
        // R7: start while open
        step(1'b0, 32'h0000_0001, 1, 0, 0, 0, 2'b00, 1'b1);
        step(1'b0, 32'h0000_0002, 1, 0, 0, 0, 2'b00, 1'b1);
        step(1'b0, 32'h0000_0003, 0, 1, 0, 0, 2'b00, 1'b1);
        idle(6, 1'b1);

        // R9 / R10: hysteresis with a stalled reader
        stop_lvl = CW'(8); resume_lvl = CW'(10);
        step(1'b0, $urandom, 1, 0, 0, 0, 2'b00, 1'b0);
        for (int k = 1; k < 8; k++) step(1'b0, $urandom, 0, 0, 0, 0, 2'b00, 1'b0);
        chk(rx_room == 1'b0, "R9", 64'(rx_room), 64'd0);
        while (mq.size() > 6) step(1'b1, 0, 0, 0, 0, 0, 0, 1'b1);
        chk(rx_room == 1'b0, "R10", 64'(rx_room), 64'd0);
        step(1'b1, 0, 0, 0, 0, 0, 0, 1'b1);
        chk(rx_room == 1'b1, "R10", 64'(rx_room), 64'd1);
        step(1'b0, $urandom, 0, 1, 0, 0, 2'b01, 1'b1);
        idle(12, 1'b1);

        // R12: forced writes into a full queue
        stop_lvl = CW'(16); resume_lvl = CW'(4);
        step(1'b0, $urandom, 1, 0, 0, 0, 2'b00, 1'b0);
        for (int k = 1; k < 19; k++) step(1'b0, $urandom, 0, 0, 0, 0, 2'b00, 1'b0);
        step(1'b0, $urandom, 0, 1, 0, 0, 2'b00, 1'b0);
        pops = 0;
        idle(24, 1'b1);
        chk(pops == DEPTH, "R12", 64'(pops), 64'(DEPTH));

        // Random traffic honouring the room flag
        stop_lvl = CW'(12); resume_lvl = CW'(6);
        in_pkt = m_open;
        for (int c = 0; c < 3000; c++) begin
            if (rx_room && ($urandom % 4 != 0)) begin
                bit e;
                e = ($urandom % 4 == 0);
                step(1'b0, $urandom, !in_pkt, e, ($urandom % 16 == 0), ($urandom % 16 == 0),
                     2'($urandom), ($urandom % 3 != 0));
                in_pkt = !e;
            end else begin
                step(1'b1, $urandom, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                     2'($urandom), ($urandom % 3 != 0));
            end
        end
        idle(24, 1'b1);
        chk(rd_valid == 1'b0, "R2", 64'(rd_valid), 64'd0);
        finish_run();
    end
endmodule